// File: doc/BRIEF.md
# Four-Bit Shared-Bus Processor

This block is a very small 4-bit processor organised around one main bus. A 16-word program store holds 8-bit words. Each word joins a 4-bit immediate (high nibble) with a 4-bit command (low nibble). Three sources can reach the bus: the immediate of the instruction being executed, the output of a combinational adder/subtractor fed by two operand registers, and the data RAM word selected by the address register. Which sources drive the bus is not chosen per instruction. Each source has an enable flag that the program flips with toggle commands. The other commands load a unit from the bus.

Every instruction takes two clock cycles. In the first cycle the word at the program counter is latched and the counter steps forward. In the second cycle the command executes against the bus. The program store is filled through a write port, normally while reset is held. A debug port reads any RAM word without disturbing execution. The program counter, the bus value and a flag for more than one enabled source are brought out for observation.

Top module: `cpu4_core`

## Requirements
- R1: A program word is 8 bits wide: bits 7:4 are the immediate and bits 3:0 are the command. Words are fetched in order from address 0 after reset.
- R2: The bus is the bitwise OR of the enabled sources: the immediate of the instruction latched last, the ALU result, and the RAM word at the address register. With no source enabled the bus reads 0.
- R3: `busConflict` is 1 exactly when two or more bus sources are enabled.
- R4: The ALU output is B+C mod 16 in add mode and B-C mod 16 in subtract mode. Command 8 flips the mode. Reset selects add.
- R5: Command 4 writes the bus value into the RAM word at the address register. Commands 0, 1 and 2 load the address register, B and C from the bus.
- R6: Command 3 loads the program counter from the bus unconditionally.
- R7: Command 9 loads the program counter from the bus only when B equals C. Otherwise execution continues in sequence.
- R8: Reset clears the program counter, the address register, B, C, every RAM word, every bus enable and the latched word, and selects add mode. It leaves the program store intact.
- R9: Commands 5, 6 and 7 flip the enable of the ALU, immediate and RAM source respectively. A flip takes effect from the next instruction, and a second flip closes the source again.
- R10: Commands 10 to 15 change no state apart from the normal program counter step.
- R11: The program counter steps once per two clock cycles: it advances on the first edge after reset and holds on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| romWe | input | 1 | Program store write strobe |
| romWrAddr | input | 4 | Program store write address |
| romWrData | input | 8 | Program store write word |
| dbgAddr | input | 4 | RAM debug read address |
| dbgData | output | 4 | RAM word at dbgAddr |
| pcOut | output | 4 | Program counter |
| busOut | output | 4 | Current main bus value |
| busConflict | output | 1 | More than one bus source enabled |

## Verification
The hardest situation to reach is a bus with several sources enabled at once while loads and a conditional branch act on that merged value. The toggle state only builds up through a run of earlier instructions. Directed programs open the immediate and ALU sources together and branch on equal operands. Programs built from $urandom with a fixed seed then wander through arbitrary enable combinations, backward jumps and mode flips. After each run the bench compares the program counter, bus, conflict flag and all sixteen RAM words with an instruction-level model.

// File: rtl/cpu4_pkg.sv
package cpu4_pkg;

  localparam int CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_LD_ADDR = 4'd0,
    CMD_LD_B    = 4'd1,
    CMD_LD_C    = 4'd2,
    CMD_LD_PC   = 4'd3,
    CMD_LD_RAM  = 4'd4,
    CMD_TG_ALU  = 4'd5,
    CMD_TG_IMM  = 4'd6,
    CMD_TG_RAM  = 4'd7,
    CMD_TG_MODE = 4'd8,
    CMD_BR_EQ   = 4'd9
  } cmd_e;

  typedef struct packed {
    logic fetch;
    logic ldAddr;
    logic ldB;
    logic ldC;
    logic ldPc;
    logic ldPcEq;
    logic ldRam;
    logic tgAlu;
    logic tgImm;
    logic tgRam;
    logic tgMode;
  } strobe_t;

  localparam int SRC_N   = 3;
  localparam int SRC_IMM = 0;
  localparam int SRC_ALU = 1;
  localparam int SRC_RAM = 2;

endpackage

// File: rtl/cpu4_ctrl.sv
module cpu4_ctrl
  import cpu4_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CMD_W-1:0] cmd,
  output strobe_t          st
);

  logic execPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) execPhase <= 1'b0;
    else       execPhase <= ~execPhase;
  end

  always_comb begin
    st = '0;
    st.fetch = ~execPhase;
    if (execPhase) begin
      case (cmd_e'(cmd))
        CMD_LD_ADDR: st.ldAddr = 1'b1;
        CMD_LD_B:    st.ldB    = 1'b1;
        CMD_LD_C:    st.ldC    = 1'b1;
        CMD_LD_PC:   st.ldPc   = 1'b1;
        CMD_LD_RAM:  st.ldRam  = 1'b1;
        CMD_TG_ALU:  st.tgAlu  = 1'b1;
        CMD_TG_IMM:  st.tgImm  = 1'b1;
        CMD_TG_RAM:  st.tgRam  = 1'b1;
        CMD_TG_MODE: st.tgMode = 1'b1;
        CMD_BR_EQ:   st.ldPcEq = 1'b1;
        default: ;
      endcase
    end
  end

  // R11: fetch and execute alternate
  p_phase_alt_r11: assert property (@(posedge clk) disable iff (!rstN)
    st.fetch |=> !st.fetch);

  // R10: at most one action strobe per execute cycle
  p_one_action_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.ldAddr, st.ldB, st.ldC, st.ldPc, st.ldPcEq, st.ldRam,
              st.tgAlu, st.tgImm, st.tgRam, st.tgMode}));

endmodule

// File: rtl/cpu4_dpath.sv
module cpu4_dpath
  import cpu4_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    romWe,
  input  logic [DATA_W-1:0]       romWrAddr,
  input  logic [DATA_W+CMD_W-1:0] romWrData,
  input  strobe_t                 st,
  output logic [CMD_W-1:0]        cmd,
  input  logic [DATA_W-1:0]       dbgAddr,
  output logic [DATA_W-1:0]       dbgData,
  output logic [DATA_W-1:0]       pcOut,
  output logic [DATA_W-1:0]       busOut,
  output logic                    busConflict
);

  localparam int DEPTH  = 1 << DATA_W;
  localparam int WORD_W = DATA_W + CMD_W;

  logic [WORD_W-1:0] romMem [DEPTH];
  logic [DATA_W-1:0] ramMem [DEPTH];
  logic [WORD_W-1:0] instWord;
  logic [DATA_W-1:0] pc, addrReg, regB, regC, aluOut, busVal;
  logic [DATA_W-1:0] srcData [SRC_N];
  logic [SRC_N-1:0]  srcEn;
  logic              subMode, opEq;

  always_ff @(posedge clk) begin
    if (romWe) romMem[romWrAddr] <= romWrData;
  end

  assign aluOut = subMode ? (regB - regC) : (regB + regC);
  assign opEq   = (regB == regC);

  assign srcData[SRC_IMM] = instWord[WORD_W-1:CMD_W];
  assign srcData[SRC_ALU] = aluOut;
  assign srcData[SRC_RAM] = ramMem[addrReg];

  always_comb begin
    busVal = '0;
    for (int s = 0; s < SRC_N; s++) begin
      if (srcEn[s]) busVal = busVal | srcData[s];
    end
  end

  assign busConflict = (srcEn & (srcEn - 1'b1)) != '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc       <= '0;
      instWord <= '0;
      addrReg  <= '0;
      regB     <= '0;
      regC     <= '0;
      subMode  <= 1'b0;
      srcEn    <= '0;
    end else begin
      if (st.fetch) begin
        instWord <= romMem[pc];
        pc       <= pc + 1'b1;
      end
      if (st.ldPc || (st.ldPcEq && opEq)) pc <= busVal;
      if (st.ldAddr) addrReg <= busVal;
      if (st.ldB)    regB    <= busVal;
      if (st.ldC)    regC    <= busVal;
      if (st.tgMode) subMode <= ~subMode;
      if (st.tgImm)  srcEn[SRC_IMM] <= ~srcEn[SRC_IMM];
      if (st.tgAlu)  srcEn[SRC_ALU] <= ~srcEn[SRC_ALU];
      if (st.tgRam)  srcEn[SRC_RAM] <= ~srcEn[SRC_RAM];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) ramMem[i] <= '0;
    end else if (st.ldRam) begin
      ramMem[addrReg] <= busVal;
    end
  end

  assign cmd     = instWord[CMD_W-1:0];
  assign dbgData = ramMem[dbgAddr];
  assign pcOut   = pc;
  assign busOut  = busVal;

  // R11: a fetch always advances the counter by one
  p_fetch_step_r11: assert property (@(posedge clk) disable iff (!rstN)
    st.fetch |=> pc == $past(pc) + 1'b1);

  // R6 / R7: an execute cycle without a taken load keeps the counter
  p_pc_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!st.fetch && !st.ldPc && !(st.ldPcEq && opEq)) |=> $stable(pc));

  // R5: the word under the address register takes the bus value
  p_ram_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.ldRam |=> ramMem[$past(addrReg)] == $past(busVal));

  // R9: a toggle flips the immediate enable
  p_imm_toggle_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.tgImm |=> srcEn[SRC_IMM] != $past(srcEn[SRC_IMM]));

  // R4: the mode bit only moves on its own command
  p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !st.tgMode |=> $stable(subMode));

  // R2: a closed bus reads zero
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (srcEn == '0) |-> (busVal == '0));

endmodule

// File: rtl/cpu4_core.sv
module cpu4_core
  import cpu4_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    romWe,
  input  logic [DATA_W-1:0]       romWrAddr,
  input  logic [DATA_W+CMD_W-1:0] romWrData,
  input  logic [DATA_W-1:0]       dbgAddr,
  output logic [DATA_W-1:0]       dbgData,
  output logic [DATA_W-1:0]       pcOut,
  output logic [DATA_W-1:0]       busOut,
  output logic                    busConflict
);

  strobe_t          st;
  logic [CMD_W-1:0] cmd;

  cpu4_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .cmd  (cmd),
    .st   (st)
  );

  cpu4_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .romWe       (romWe),
    .romWrAddr   (romWrAddr),
    .romWrData   (romWrData),
    .st          (st),
    .cmd         (cmd),
    .dbgAddr     (dbgAddr),
    .dbgData     (dbgData),
    .pcOut       (pcOut),
    .busOut      (busOut),
    .busConflict (busConflict)
  );

endmodule

// File: tb/cpu4_core_tb.sv
module cpu4_core_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       romWe = 1'b0;
  logic [3:0] romWrAddr = '0;
  logic [7:0] romWrData = '0;
  logic [3:0] dbgAddr = '0;
  logic [3:0] dbgData, pcOut, busOut;
  logic       busConflict;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  logic [7:0] prog [16];
  logic [3:0] mRam [16];
  logic [3:0] mPc, mA, mB, mC, mImm;
  logic       mSub, mEnImm, mEnAlu, mEnRam;

  cpu4_core dut_i (
    .clk(clk), .rstN(rstN), .romWe(romWe), .romWrAddr(romWrAddr),
    .romWrData(romWrData), .dbgAddr(dbgAddr), .dbgData(dbgData),
    .pcOut(pcOut), .busOut(busOut), .busConflict(busConflict)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cycles);
      summary();
    end
  end

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] mAlu();
    return mSub ? (mB - mC) : (mB + mC);
  endfunction

  function automatic logic [3:0] mBus();
    logic [3:0] v;
    v = '0;
    if (mEnImm) v = v | mImm;
    if (mEnAlu) v = v | mAlu();
    if (mEnRam) v = v | mRam[mA];
    return v;
  endfunction

  task automatic modelReset();
    mPc = 0; mA = 0; mB = 0; mC = 0; mImm = 0;
    mSub = 0; mEnImm = 0; mEnAlu = 0; mEnRam = 0;
    for (int i = 0; i < 16; i++) mRam[i] = 0;
  endtask

  task automatic modelStep();
    logic [7:0] w;
    logic [3:0] b;
    w = prog[mPc];
    mPc = mPc + 1;
    mImm = w[7:4];
    b = mBus();
    case (w[3:0])
      4'd0: mA = b;
      4'd1: mB = b;
      4'd2: mC = b;
      4'd3: mPc = b;
      4'd4: mRam[mA] = b;
      4'd5: mEnAlu = ~mEnAlu;
      4'd6: mEnImm = ~mEnImm;
      4'd7: mEnRam = ~mEnRam;
      4'd8: mSub = ~mSub;
      4'd9: if (mB == mC) mPc = b;
      default: ;
    endcase
  endtask

  // load program under reset, release, run n instructions
  task automatic runProg(int n);
    @(negedge clk);
    rstN = 1'b0;
    for (int i = 0; i < 16; i++) begin
      romWe = 1'b1; romWrAddr = 4'(i); romWrData = prog[i];
      @(negedge clk);
    end
    romWe = 1'b0;
    rstN = 1'b1;
    modelReset();
    repeat (2*n) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < n; i++) modelStep();
  endtask

  task automatic compareAll(string tag);
    chk({tag, " R6 R7 R11 pc"}, pcOut, mPc);
    chk({tag, " R2 bus"}, busOut, mBus());
    chk({tag, " R3 conflict"}, busConflict,
        (int'(mEnImm) + int'(mEnAlu) + int'(mEnRam)) > 1);
    for (int i = 0; i < 16; i++) begin
      dbgAddr = 4'(i);
      #1;
      chk({tag, " R5 ram"}, dbgData, mRam[i]);
    end
  endtask

  task automatic clearProg();
    for (int i = 0; i < 16; i++) prog[i] = 8'h0F;
  endtask

  initial begin
    void'($urandom(17));

    // R8: reset state, with program store kept
    clearProg();
    prog[0] = 8'h06; prog[1] = 8'h51;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      romWe = 1'b1; romWrAddr = 4'(i); romWrData = prog[i];
      @(negedge clk);
    end
    romWe = 1'b0;
    chk("R8 pc reset", pcOut, 0);
    chk("R8 bus reset", busOut, 0);
    chk("R8 conflict reset", busConflict, 0);
    dbgAddr = 4'd3; #1;
    chk("R8 ram reset", dbgData, 0);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R11 pc after first edge", pcOut, 1);
    @(posedge clk); @(negedge clk);
    chk("R11 pc holds on execute edge", pcOut, 1);

    // R1 R4 R5: 2+2 stored at address 0
    clearProg();
    prog[0] = 8'h06; prog[1] = 8'h21; prog[2] = 8'h22; prog[3] = 8'h00;
    prog[4] = 8'h06; prog[5] = 8'h05; prog[6] = 8'h04;
    runProg(7);
    dbgAddr = 4'd0; #1;
    chk("R1 R4 R5 two plus two", dbgData, 4);
    compareAll("sum");

    // R4: subtract wraps, result at address 3
    clearProg();
    prog[0] = 8'h06; prog[1] = 8'h31; prog[2] = 8'h52; prog[3] = 8'h30;
    prog[4] = 8'h06; prog[5] = 8'h08; prog[6] = 8'h05; prog[7] = 8'h04;
    runProg(8);
    dbgAddr = 4'd3; #1;
    chk("R4 subtract wrap", dbgData, 14);
    compareAll("sub");

    // R2 R3: immediate and ALU both open, OR on the bus
    clearProg();
    prog[0] = 8'h06; prog[1] = 8'h71; prog[2] = 8'h12; prog[3] = 8'h35;
    runProg(4);
    chk("R3 conflict raised", busConflict, 1);
    chk("R2 OR of sources", busOut, 4'h3 | 4'h8);

    // R9: second toggle closes the immediate source
    clearProg();
    prog[0] = 8'h06; prog[1] = 8'h91; prog[2] = 8'h96;
    runProg(3);
    chk("R9 closed again bus zero", busOut, 0);
    chk("R9 closed again conflict", busConflict, 0);

    // R7: branch taken when B == C
    clearProg();
    prog[0] = 8'h06; prog[1] = 8'h11; prog[2] = 8'h12; prog[3] = 8'h99;
    runProg(4);
    chk("R7 branch taken", pcOut, 9);
    // R7: not taken
    prog[2] = 8'h22;
    runProg(4);
    chk("R7 branch not taken", pcOut, 4);
    // R6: unconditional jump
    clearProg();
    prog[0] = 8'h06; prog[1] = 8'hA3;
    runProg(2);
    chk("R6 jump", pcOut, 10);

    // R10: unused codes with the immediate open change nothing
    clearProg();
    prog[0] = 8'h06;
    for (int i = 1; i < 12; i++) prog[i] = {4'(i), 4'(10 + (i % 6))};
    runProg(12);
    chk("R10 pc only steps", pcOut, 12);
    compareAll("R10 unused");

    // random programs against the model
    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < 16; i++) prog[i] = 8'($urandom);
      runProg(5 + int'($urandom % 40));
      compareAll("random");
    end

    summary();
  end

endmodule